// File: doc/BRIEF.md
# Peripheral Request Routing Table

This block sits between a chip's peripherals and its DMA channels. Every peripheral drives one level-sensitive request line. A programmable table holds one entry per request line. Each entry names the DMA channel that the request should pace and carries a flag that enables the mapping. The block brings each request line into the local clock domain, looks up its entry and raises the request input of the chosen channel. The same routed level is also reported per channel as a request-pending status.

Software programs the table through a simple word-wide register port. Request numbers 0 to 63 occupy one address window and request numbers 64 and above occupy a second, separate window. A write of zero removes a mapping. When several mapped requests name the same channel, their levels are merged. A channel's request input is raised only while that channel declares that its current transfer is paced by a peripheral. The pending status does not depend on that declaration.

Top module: `req_router`

## Requirements
- R1: After reset every table entry reads as zero (unmapped), `chan_pend`, `chan_req` and `reg_rdata` are all zero, and no request reaches any channel.
- R2: The entry for request n (n < 64) sits at byte address 0x100 + 4·n, and the entry for request n (n ≥ 64) sits at 0x1100 + 4·(n − 64). Address bits 1:0 are ignored.
- R3: An entry stores the map-enable flag from data bit 7 and the channel number from data bits 4:0. A read returns the flag in bit 7 and the channel in bits 4:0, and every other bit reads as zero.
- R4: A read (`reg_en`=1, `reg_write`=0) updates `reg_rdata` at the next clock edge, and `reg_rdata` holds its value until the next read. A read outside both windows returns zero. A write outside both windows changes no entry.
- R5: A request line that is high on two consecutive rising edges, and whose entry has the flag set, raises bit `ch` of `chan_pend` right after the second of those edges. It stays raised while the line stays high. It falls two edges after the line falls.
- R6: Clearing the map-enable flag, for example by writing zero, stops the request from reaching any channel from the edge that performs the write.
- R7: Requests from several enabled entries that name the same channel are ORed onto that channel.
- R8: `chan_req[c]` equals `chan_pend[c]` while `chan_flow_en[c]` is 1 and is 0 otherwise. This is a combinational gate with no added latency.
- R9: Rewriting the entry of an active request to a new channel moves the request at the write edge: only the old channel before it, only the new channel after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (13) | Byte address of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, registered |
| req_in | input | NUM_REQ (128) | Peripheral request levels, asynchronous |
| chan_flow_en | input | NUM_CH (32) | Per channel: current transfer is peripheral paced |
| chan_req | output | NUM_CH (32) | Request input to each channel's flow control |
| chan_pend | output | NUM_CH (32) | Per-channel request-pending status |

## Verification
A table write can land in the same cycle in which the request it governs is already active at the synchronizer output. This is the case when a held request is unmapped or moved to another channel. The bench provokes it by holding a routed request steady and issuing the write. It samples the channel outputs on the falling edges just before and just after the write's rising edge. The result is judged correct only if the old channel is driven before that edge, and only the new channel (or none) after it, with no cycle in which both channels or a stale mapping show.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
    // Channel-number field width in a table entry and the flag position.
    localparam int unsigned CH_FIELD_W = 5;
    localparam int unsigned VLD_BIT    = 7;
    // Address windows: upper address bits [12:8] select the window.
    localparam logic [4:0]  LO_WIN_TAG = 5'h01;   // 0x0100..0x01FF
    localparam logic [4:0]  HI_WIN_TAG = 5'h11;   // 0x1100..0x11FF
    localparam int unsigned WIN_SLOTS  = 64;

    typedef struct packed {
        logic                  vld;
        logic [CH_FIELD_W-1:0] ch;
    } map_ent_t;
endpackage

// File: rtl/rr_sync.sv
`timescale 1ns/1ps
module rr_sync #(
    parameter int unsigned W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/rr_map_table.sv
`timescale 1ns/1ps
module rr_map_table
    import rr_pkg::*;
#(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_en,
    input  logic                     reg_write,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output map_ent_t [NUM_REQ-1:0]   map_o
);
    localparam int unsigned SLOT_W = $clog2(WIN_SLOTS);
    localparam int unsigned IDX_W  = SLOT_W + 1;

    typedef struct packed {
        map_ent_t [NUM_REQ-1:0] ent;
        logic [DATA_W-1:0]      rdata;
    } tbl_t;

    tbl_t st_d, st_q;

    logic             in_lo, in_hi, hit;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_lo = (reg_addr[ADDR_W-1:8] == LO_WIN_TAG);
        in_hi = (reg_addr[ADDR_W-1:8] == HI_WIN_TAG);
        idx   = {in_hi, reg_addr[SLOT_W+1:2]};
        hit   = (in_lo || in_hi) && (32'(idx) < NUM_REQ);
    end

    always_comb begin
        st_d = st_q;
        if (reg_en && reg_write && hit) begin
            st_d.ent[idx].vld = reg_wdata[VLD_BIT];
            st_d.ent[idx].ch  = reg_wdata[CH_FIELD_W-1:0];
        end
        if (reg_en && !reg_write) begin
            st_d.rdata = '0;
            if (hit) begin
                st_d.rdata[VLD_BIT]         = st_q.ent[idx].vld;
                st_d.rdata[CH_FIELD_W-1:0]  = st_q.ent[idx].ch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign map_o     = st_q.ent;
endmodule

// File: rtl/rr_route.sv
`timescale 1ns/1ps
module rr_route
    import rr_pkg::*;
#(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned NUM_CH  = 32
) (
    input  map_ent_t [NUM_REQ-1:0] map_i,
    input  logic [NUM_REQ-1:0]     req_i,
    output logic [NUM_CH-1:0]      pend_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic any_hit;
        always_comb begin
            any_hit = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (req_i[r] && map_i[r].vld && (map_i[r].ch == CH_FIELD_W'(c)))
                    any_hit = 1'b1;
            end
        end
        assign pend_o[c] = any_hit;
    end
endmodule

// File: rtl/req_router.sv
`timescale 1ns/1ps
module req_router
    import rr_pkg::*;
#(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic [NUM_CH-1:0] chan_flow_en,
    output logic [NUM_CH-1:0] chan_req,
    output logic [NUM_CH-1:0] chan_pend
);
    logic [NUM_REQ-1:0]     req_sync;
    map_ent_t [NUM_REQ-1:0] map_tbl;
    logic [NUM_CH-1:0]      routed;

    rr_sync #(.W(NUM_REQ)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_in),
        .sync_o  (req_sync)
    );

    rr_map_table #(
        .NUM_REQ (NUM_REQ),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .map_o     (map_tbl)
    );

    rr_route #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) i_route (
        .map_i  (map_tbl),
        .req_i  (req_sync),
        .pend_o (routed)
    );

    assign chan_pend = routed;
    assign chan_req  = routed & chan_flow_en;
endmodule

// File: rtl/rr_checker.sv
`timescale 1ns/1ps
module rr_checker #(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NUM_REQ-1:0] req_in,
    input logic [NUM_CH-1:0] chan_flow_en,
    input logic [NUM_CH-1:0] chan_req,
    input logic [NUM_CH-1:0] chan_pend
);
    logic       win_lo, win_hi, outside;
    logic [6:0] slot;

    always_comb begin
        win_lo  = (reg_addr[ADDR_W-1:8] == 5'h01);
        win_hi  = (reg_addr[ADDR_W-1:8] == 5'h11);
        slot    = {win_hi, reg_addr[7:2]};
        outside = !(win_lo || win_hi) || (32'(slot) >= NUM_REQ);
    end

    AST_REQ_NEEDS_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req & ~chan_flow_en) == '0);  // R8

    AST_PEND_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_pend) |-> (|$past(req_in, 2)));  // R5

    AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|req_in) && !(|$past(req_in))) |=> !(|chan_pend));  // R5

    AST_READ_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_write && outside) |=> (reg_rdata == '0));  // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_write) |=> $stable(reg_rdata));  // R4

    AST_RDATA_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:8] == '0) && (reg_rdata[6:5] == 2'b00));  // R3
endmodule

bind req_router rr_checker #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) i_rr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_en       (reg_en),
    .reg_write    (reg_write),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .req_in       (req_in),
    .chan_flow_en (chan_flow_en),
    .chan_req     (chan_req),
    .chan_pend    (chan_pend)
);

// File: tb/test_req_router.sv
`timescale 1ns/1ps
module test_req_router;
    localparam int unsigned NUM_REQ = 128;
    localparam int unsigned NUM_CH  = 32;
    localparam int unsigned ADDR_W  = 13;
    localparam int unsigned DATA_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_en = 1'b0;
    logic              reg_write = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NUM_REQ-1:0] req_in = '0;
    logic [NUM_CH-1:0] chan_flow_en = '1;
    logic [NUM_CH-1:0] chan_req;
    logic [NUM_CH-1:0] chan_pend;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    req_router #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) i_req_router (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_en       (reg_en),
        .reg_write    (reg_write),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .req_in       (req_in),
        .chan_flow_en (chan_flow_en),
        .chan_req     (chan_req),
        .chan_pend    (chan_pend)
    );

    typedef struct packed {
        logic [12:0] addr;
        logic [31:0] data;
        logic [6:0]  req;
        logic [31:0] exp;
    } vec_t;

    // Write an entry, raise one request, expect this channel mask (R2, R3, R5, R6).
    localparam vec_t VECS [8] = '{
        '{13'h0100, 32'h0000_0083, 7'd0,   32'h0000_0008},
        '{13'h1100, 32'h0000_0085, 7'd64,  32'h0000_0020},
        '{13'h11FC, 32'h0000_009F, 7'd127, 32'h8000_0000},
        '{13'h01FC, 32'h0000_0080, 7'd63,  32'h0000_0001},
        '{13'h013E, 32'h0000_008A, 7'd15,  32'h0000_0400},
        '{13'h0104, 32'h0000_0007, 7'd1,   32'h0000_0000},
        '{13'h1104, 32'h0000_00FF, 7'd65,  32'h8000_0000},
        '{13'h1108, 32'h0000_0000, 7'd66,  32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pend after reset", chan_pend, 32'h0);
        chk("R1 req after reset", chan_req, 32'h0);
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        rd(13'h1100, rv);
        chk("R1 entry reads zero", rv, 32'h0);
        req_in = '1;
        @(negedge clk); @(negedge clk);
        chk("R1 unmapped requests route nowhere", chan_pend, 32'h0);
        req_in = '0;
        @(negedge clk); @(negedge clk);

        // Vector walk: R2 window decode, R3 fields, R5 routing, R6 flag clear
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].addr, VECS[i].data);
            req_in = '0;
            req_in[VECS[i].req] = 1'b1;
            @(negedge clk); @(negedge clk);
            chk($sformatf("R2/R5 vector %0d pend", i), chan_pend, VECS[i].exp);
            chk($sformatf("R8 vector %0d req", i), chan_req, VECS[i].exp);
            req_in = '0;
            @(negedge clk); @(negedge clk);
            chk($sformatf("R5 vector %0d release", i), chan_pend, 32'h0);
        end

        // R3: readback format
        rd(13'h1104, rv);
        chk("R3 read masks reserved bits", rv, 32'h0000_009F);
        rd(13'h0104, rv);
        chk("R3 read flag clear entry", rv, 32'h0000_0007);
        rd(13'h013C, rv);
        chk("R2 byte bits ignored", rv, 32'h0000_008A);

        // R4: outside windows, hold
        wr(13'h0200, 32'h0000_0081);
        rd(13'h0200, rv);
        chk("R4 outside read zero", rv, 32'h0);
        rd(13'h0100, rv);
        chk("R4 outside write harmless", rv, 32'h0000_0083);
        repeat (3) @(negedge clk);
        chk("R4 rdata holds", reg_rdata, 32'h0000_0083);

        // R5: two-edge latency
        req_in[64] = 1'b1;
        @(negedge clk);
        chk("R5 one edge not yet", chan_pend, 32'h0);
        @(negedge clk);
        chk("R5 two edges routed", chan_pend, 32'h0000_0020);

        // R9: retarget while active
        reg_en = 1'b1; reg_write = 1'b1; reg_addr = 13'h1100; reg_wdata = 32'h89;
        chk("R9 before write edge old channel", chan_pend, 32'h0000_0020);
        @(negedge clk);
        reg_en = 1'b0; reg_write = 1'b0;
        chk("R9 after write edge new channel", chan_pend, 32'h0000_0200);

        // R8: flow gating
        chan_flow_en = ~32'h0000_0200;
        #1;
        chk("R8 gated req", chan_req, 32'h0);
        chk("R8 pend ungated", chan_pend, 32'h0000_0200);
        chan_flow_en = '1;
        #1;
        chk("R8 req passes", chan_req, 32'h0000_0200);

        // R6: unmap while active
        @(negedge clk);
        reg_en = 1'b1; reg_write = 1'b1; reg_addr = 13'h1100; reg_wdata = 32'h0;
        @(negedge clk);
        reg_en = 1'b0; reg_write = 1'b0;
        chk("R6 unmap at write edge", chan_pend, 32'h0);
        req_in = '0;

        // R7: merge onto one channel
        wr(13'h0108, 32'h0000_0083);
        req_in[0] = 1'b1; req_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R7 both to channel 3", chan_pend, 32'h0000_0008);
        req_in[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 one of two still drives", chan_pend, 32'h0000_0008);
        req_in = '0;
        @(negedge clk); @(negedge clk);
        chk("R7 none drives", chan_pend, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule